// File: doc/BRIEF.md
# Write-Protect Command Sequence Detector

This block sits beside the page-write controller of an electrically erasable memory. It watches every byte-load strobe (address plus data) and decides, byte by byte and then once per page operation, whether the loaded data may reach the array. Short command sequences written at the start of a page operation switch a protection flag on or off. While protection is on, a page operation may still commit if it opens with the locking sequence. A write without that sequence is refused: nothing is stored, but the write timer still runs, so reads behave as polling reads for that cycle time.

A page operation opens with the first accepted strobe. It closes when no strobe has arrived for `LOAD_WIN` clock cycles. At the close the block pulses `op_close` and gives the verdict on `commit_ok` and `suppress_data`. The controller then starts its internal write timer and raises `busy`. A newly written lock sequence takes effect only when that timed cycle ends. The flag is nonvolatile in the memory it guards, so here it is cleared only by the initialisation reset `init_n`, which gives the unprotected shipped state. The ordinary reset `rst_n` leaves it untouched.

Top module: `wp_guard`

## Requirements
- R1: After `init_n` is released, `prot_on`, `load_en`, `op_close`, `commit_ok` and `suppress_data` are all 0.
- R2: While unprotected, a data strobe gives `load_en`=1 in the cycle after it. When the window closes, `op_close`=1 with `commit_ok`=1 and `suppress_data`=0.
- R3: The lock sequence is AAh to address 5555h, then 55h to 2AAAh, then A0h to 5555h, as the first writes of an operation. None of its bytes is loaded (`load_en`=0), and the operation commits at its close. `prot_on` stays 0 until the cycle after `busy` falls following that close, and becomes 1 then.
- R4: While protected, an operation that does not open with the lock sequence loads nothing. It closes with `commit_ok`=0 and `suppress_data`=1. The permission granted by a lock sequence ends when its operation closes.
- R5: While protected, an operation that opens with the lock sequence loads its following data bytes and closes with `commit_ok`=1 and `suppress_data`=0.
- R6: The unlock sequence is AAh/5555h, 55h/2AAAh, 80h/5555h, AAh/5555h, 55h/2AAAh, 20h/5555h. None of its bytes is loaded. `prot_on` falls in the cycle after the sixth byte, and data later in the same operation is loaded and commits.
- R7: A write that departs from the expected next step is itself a data byte, and the bytes of the partial sequence before it are never loaded. Once an operation holds a data byte or a finished sequence, every later write in that operation is data, including AAh to 5555h.
- R8: An operation closes `LOAD_WIN` cycles after its last accepted strobe, with a one-cycle `op_close` pulse. A sequence split across two operations does not count.
- R9: A strobe while `busy`=1 is ignored. It loads nothing, opens no window and does not advance a sequence.
- R10: `rst_n` alone does not change `prot_on`. `init_n` clears it.
- R11: Command steps need an exact match on all `CMD_AW` address bits and on all eight data bits. AAh to 5554h, or ABh to 5555h, is ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| init_n | input | 1 | Asynchronous active-low initialisation reset; also clears the protection flag |
| rst_n | input | 1 | Asynchronous active-low functional reset; keeps the protection flag |
| wr_stb | input | 1 | One-cycle byte-load strobe |
| wr_addr | input | CMD_AW | Byte-load address (bits used for command decode) |
| wr_data | input | 8 | Byte-load data |
| busy | input | 1 | Internal write cycle in progress |
| prot_on | output | 1 | Protection flag |
| load_en | output | 1 | The byte of the previous strobe goes into the page buffer |
| op_close | output | 1 | Page operation closed this cycle |
| commit_ok | output | 1 | With op_close: start a write cycle that stores the page |
| suppress_data | output | 1 | With op_close: start a write cycle that stores nothing |

## Verification
The bench builds the block with `LOAD_WIN` set to 6 and the command address width left at 15 bits. The short window lets one run chain many operations: the lock, refused, unlocked and unlock paths, plus a sequence split by a window close. It also lets the run confirm that a `busy` phase longer than the window opens nothing. With a 15-bit address, the near-miss addresses 5554h and 5555h differ only in the lowest bit, so the exact-match rule can be checked there.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // sequence matcher states
  typedef enum logic [2:0] {
    M_IDLE,   // waiting for first key of an operation
    M_K1,     // first key seen
    M_K2,     // second key seen, expecting lock or extend code
    M_X1,     // extend code seen
    M_X2,     // repeated first key seen
    M_X3,     // repeated second key seen
    M_PARK    // operation carries data or a finished sequence
  } mstate_e;

  localparam logic [7:0] KEY_1   = 8'hAA;
  localparam logic [7:0] KEY_2   = 8'h55;
  localparam logic [7:0] OP_LOCK = 8'hA0;
  localparam logic [7:0] OP_EXT  = 8'h80;
  localparam logic [7:0] OP_FREE = 8'h20;

endpackage

// File: rtl/wp_rst_sync.sv
module wp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wp_seq_match.sv
module wp_seq_match
  import wp_pkg::*;
#(
  parameter int                 CMD_AW     = 15,
  parameter logic [CMD_AW-1:0]  CMD_ADDR_A = 15'h5555,
  parameter logic [CMD_AW-1:0]  CMD_ADDR_B = 15'h2AAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              flush,
  input  logic [CMD_AW-1:0] addr,
  input  logic [7:0]        data,
  output logic              is_cmd,
  output logic              en_hit,
  output logic              dis_hit
);

  mstate_e st_q, st_d;
  logic    at_a, at_b;

  assign at_a = (addr == CMD_ADDR_A);
  assign at_b = (addr == CMD_ADDR_B);

  // next state; a departing write parks the matcher for the operation
  always_comb begin
    st_d    = st_q;
    is_cmd  = 1'b0;
    en_hit  = 1'b0;
    dis_hit = 1'b0;
    if (flush) begin
      st_d = M_IDLE;
    end else if (acc) begin
      st_d = M_PARK;
      unique case (st_q)
        M_IDLE: if (at_a && data == KEY_1) begin
          st_d   = M_K1;
          is_cmd = 1'b1;
        end
        M_K1: if (at_b && data == KEY_2) begin
          st_d   = M_K2;
          is_cmd = 1'b1;
        end
        M_K2: begin
          if (at_a && data == OP_LOCK) begin
            is_cmd = 1'b1;
            en_hit = 1'b1;
          end else if (at_a && data == OP_EXT) begin
            st_d   = M_X1;
            is_cmd = 1'b1;
          end
        end
        M_X1: if (at_a && data == KEY_1) begin
          st_d   = M_X2;
          is_cmd = 1'b1;
        end
        M_X2: if (at_b && data == KEY_2) begin
          st_d   = M_X3;
          is_cmd = 1'b1;
        end
        M_X3: if (at_a && data == OP_FREE) begin
          is_cmd  = 1'b1;
          dis_hit = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= M_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/wp_load_win.sv
module wp_load_win #(
  parameter int LOAD_WIN = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  output logic close_now
);

  localparam int            CW   = (LOAD_WIN > 2) ? $clog2(LOAD_WIN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LOAD_WIN - 1);

  logic          open_q, open_d;
  logic [CW-1:0] gap_q, gap_d;
  logic          win_en;

  assign close_now = open_q & ~acc & (gap_q == LAST);
  assign win_en    = acc | open_q;

  always_comb begin
    open_d = open_q;
    gap_d  = gap_q;
    if (acc) begin
      open_d = 1'b1;
      gap_d  = '0;
    end else if (close_now) begin
      open_d = 1'b0;
      gap_d  = '0;
    end else if (open_q) begin
      gap_d  = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      gap_q  <= '0;
    end else if (win_en) begin
      open_q <= open_d;
      gap_q  <= gap_d;
    end
  end

endmodule

// File: rtl/wp_prot_reg.sv
module wp_prot_reg (
  input  logic clk,
  input  logic init_n,
  input  logic rst_n,
  input  logic arm,
  input  logic clr,
  input  logic busy,
  output logic prot
);

  logic busy_q;
  logic pend_q, pend_d;
  logic prot_d, prot_en;
  logic busy_fall;

  assign busy_fall = busy_q & ~busy;

  always_comb begin
    pend_d = pend_q;
    if (clr)            pend_d = 1'b0;
    else if (arm)       pend_d = 1'b1;
    else if (busy_fall) pend_d = 1'b0;
  end

  assign prot_en = clr | (busy_fall & pend_q);
  assign prot_d  = ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      busy_q <= busy;
      pend_q <= pend_d;
    end
  end

  // flag survives functional reset
  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n)      prot <= 1'b0;
    else if (prot_en) prot <= prot_d;
  end

endmodule

// File: rtl/wp_guard.sv
module wp_guard #(
  parameter int                CMD_AW      = 15,
  parameter logic [CMD_AW-1:0] CMD_ADDR_A  = 15'h5555,
  parameter logic [CMD_AW-1:0] CMD_ADDR_B  = 15'h2AAA,
  parameter int                LOAD_WIN    = 25000,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              init_n,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CMD_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  output logic              prot_on,
  output logic              load_en,
  output logic              op_close,
  output logic              commit_ok,
  output logic              suppress_data
);

  logic init_s_n, fn_rst_n, fn_arst_n;
  logic acc, close_now;
  logic is_cmd, en_hit, dis_hit;
  logic has_data_q, has_data_d;
  logic unlk_q, unlk_d;
  logic flag_en;
  logic prot;

  assign fn_arst_n = rst_n & init_n;

  wp_rst_sync #(.STAGES(SYNC_STAGES)) i_init_sync (
    .clk(clk), .arst_n(init_n), .srst_n(init_s_n)
  );

  wp_rst_sync #(.STAGES(SYNC_STAGES)) i_fn_sync (
    .clk(clk), .arst_n(fn_arst_n), .srst_n(fn_rst_n)
  );

  assign acc = wr_stb & ~busy;

  wp_seq_match #(
    .CMD_AW(CMD_AW), .CMD_ADDR_A(CMD_ADDR_A), .CMD_ADDR_B(CMD_ADDR_B)
  ) i_match (
    .clk(clk), .rst_n(fn_rst_n), .acc(acc), .flush(close_now),
    .addr(wr_addr), .data(wr_data),
    .is_cmd(is_cmd), .en_hit(en_hit), .dis_hit(dis_hit)
  );

  wp_load_win #(.LOAD_WIN(LOAD_WIN)) i_win (
    .clk(clk), .rst_n(fn_rst_n), .acc(acc), .close_now(close_now)
  );

  wp_prot_reg i_prot (
    .clk(clk), .init_n(init_s_n), .rst_n(fn_rst_n),
    .arm(en_hit), .clr(dis_hit), .busy(busy), .prot(prot)
  );

  // per-operation flags
  always_comb begin
    has_data_d = has_data_q;
    unlk_d     = unlk_q;
    if (close_now) begin
      has_data_d = 1'b0;
      unlk_d     = 1'b0;
    end else begin
      if (acc && !is_cmd) has_data_d = 1'b1;
      if (en_hit)         unlk_d     = 1'b1;
    end
  end

  assign flag_en = acc | close_now;

  always_ff @(posedge clk or negedge fn_rst_n) begin
    if (!fn_rst_n) begin
      has_data_q <= 1'b0;
      unlk_q     <= 1'b0;
    end else if (flag_en) begin
      has_data_q <= has_data_d;
      unlk_q     <= unlk_d;
    end
  end

  // per-byte load decision and close verdict
  always_ff @(posedge clk or negedge fn_rst_n) begin
    if (!fn_rst_n) begin
      load_en       <= 1'b0;
      op_close      <= 1'b0;
      commit_ok     <= 1'b0;
      suppress_data <= 1'b0;
    end else begin
      load_en       <= acc & ~is_cmd & (~prot | unlk_q);
      op_close      <= close_now;
      commit_ok     <= close_now & (unlk_q | (has_data_q & ~prot));
      suppress_data <= close_now & has_data_q & prot & ~unlk_q;
    end
  end

  assign prot_on = prot;

endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic       prot_on,
  input logic       load_en,
  input logic       op_close,
  input logic       commit_ok,
  input logic       suppress_data
);

  AST_LOAD_NEEDS_STB: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> $past(wr_stb && !busy)); // R2

  AST_VERDICT_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_ok || suppress_data) |-> op_close); // R4

  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    op_close |-> !(commit_ok && suppress_data)); // R4

  AST_CLOSE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_close |=> !op_close); // R8

  AST_CLOSE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    op_close |-> !$past(wr_stb && !busy)); // R8

  AST_LOCK_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_on) |-> (!$past(busy) && $past(busy, 2))); // R3

  AST_FREE_ON_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_on) |-> ($past(wr_stb) && $past(wr_data) == wp_pkg::OP_FREE)); // R6

  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb) |=> (!load_en && $stable(prot_on))); // R9

endmodule

bind wp_guard wp_guard_chk i_chk (
  .clk(clk), .rst_n(fn_rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
  .busy(busy), .prot_on(prot_on), .load_en(load_en), .op_close(op_close),
  .commit_ok(commit_ok), .suppress_data(suppress_data)
);

// File: tb/test_wp_guard.sv
module test_wp_guard;

  localparam int LOAD_WIN = 6;
  localparam int AW       = 15;

  logic          clk = 1'b0;
  logic          init_n, rst_n, wr_stb, busy;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          prot_on, load_en, op_close, commit_ok, suppress_data;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  wp_guard #(.CMD_AW(AW), .LOAD_WIN(LOAD_WIN)) i_wp_guard (
    .clk(clk), .init_n(init_n), .rst_n(rst_n), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy),
    .prot_on(prot_on), .load_en(load_en), .op_close(op_close),
    .commit_ok(commit_ok), .suppress_data(suppress_data)
  );

  // ld: expected load_en, pr: prot after write, cl: close op after write,
  // cm/sp: verdict, bz: run a busy phase, pe: prot after busy
  typedef struct packed {
    logic [AW-1:0] addr;
    logic [7:0]    data;
    logic ld, pr, cl, cm, sp, bz, pe;
    logic [3:0]    req;
  } vec_t;

  localparam vec_t VEC [0:19] = '{
    '{15'h0123, 8'h3C, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 4'd2},  // R2
    '{15'h5555, 8'hAA, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3
    '{15'h2AAA, 8'h55, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd3},  // R3
    '{15'h5555, 8'hA0, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 4'd3},  // R3
    '{15'h0200, 8'h11, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b1, 4'd4},  // R4
    '{15'h5555, 8'hAA, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5
    '{15'h2AAA, 8'h55, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5
    '{15'h5555, 8'hA0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5
    '{15'h0300, 8'h22, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd5},  // R5
    '{15'h0301, 8'h23, 1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b1, 4'd5},  // R5
    '{15'h5555, 8'hAA, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6
    '{15'h2AAA, 8'h55, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6
    '{15'h5555, 8'h80, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6
    '{15'h5555, 8'hAA, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6
    '{15'h2AAA, 8'h55, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6
    '{15'h5555, 8'h20, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd6},  // R6
    '{15'h0400, 8'h33, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 4'd6},  // R6
    '{15'h5555, 8'hAA, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7
    '{15'h2AAA, 8'h77, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 4'd7},  // R7
    '{15'h5555, 8'hAA, 1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 4'd7}   // R7
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the sampling edge
  task automatic do_wr(input logic [AW-1:0] a, input logic [7:0] d,
                       input logic exp_ld, input string req);
    wr_stb  = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_stb  = 1'b0;
    chk(req, "load_en", 32'(load_en), 32'(exp_ld));
  endtask

  task automatic wait_close(input logic cm, input logic sp, input string req);
    int early = 0;
    repeat (LOAD_WIN - 1) begin
      @(negedge clk);
      if (op_close) early++;
    end
    chk(req, "early op_close", early, 0);
    @(negedge clk);
    chk(req, "op_close", 32'(op_close), 32'd1);
    chk(req, "commit_ok", 32'(commit_ok), 32'(cm));
    chk(req, "suppress_data", 32'(suppress_data), 32'(sp));
  endtask

  task automatic busy_cyc(input logic pre, input logic post, input string req);
    busy = 1'b1;
    repeat (3) @(negedge clk);
    busy = 1'b0;
    chk(req, "prot_on before busy falls", 32'(prot_on), 32'(pre));
    @(negedge clk);
    chk(req, "prot_on after busy falls", 32'(prot_on), 32'(post));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    init_n = 1'b0; rst_n = 1'b0; wr_stb = 1'b0; busy = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    init_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "prot_on", 32'(prot_on), 32'd0);
    chk("R1", "load_en", 32'(load_en), 32'd0);
    chk("R1", "op_close", 32'(op_close), 32'd0);
    chk("R1", "commit_ok", 32'(commit_ok), 32'd0);
    chk("R1", "suppress_data", 32'(suppress_data), 32'd0);

    // vector table
    for (int i = 0; i < 20; i++) begin
      string rq;
      rq = $sformatf("R%0d row %0d", VEC[i].req, i);
      do_wr(VEC[i].addr, VEC[i].data, VEC[i].ld, rq);
      chk(rq, "prot_on", 32'(prot_on), 32'(VEC[i].pr));
      if (VEC[i].cl) wait_close(VEC[i].cm, VEC[i].sp, rq);
      if (VEC[i].bz) busy_cyc(VEC[i].pr, VEC[i].pe, rq);
    end

    // R8: sequence split by a window close does not count
    do_wr(15'h5555, 8'hAA, 1'b0, "R8");
    do_wr(15'h2AAA, 8'h55, 1'b0, "R8");
    wait_close(1'b0, 1'b0, "R8");
    do_wr(15'h5555, 8'hA0, 1'b1, "R8");
    wait_close(1'b1, 1'b0, "R8");
    busy_cyc(1'b0, 1'b0, "R8");

    // R11: near-miss address and data are plain data
    do_wr(15'h5554, 8'hAA, 1'b1, "R11");
    wait_close(1'b1, 1'b0, "R11");
    do_wr(15'h5555, 8'hAB, 1'b1, "R11");
    do_wr(15'h2AAA, 8'h55, 1'b1, "R11");
    wait_close(1'b1, 1'b0, "R11");

    // R9: strobes while busy are ignored
    busy = 1'b1;
    do_wr(15'h5555, 8'hAA, 1'b0, "R9");
    do_wr(15'h0500, 8'h44, 1'b0, "R9");
    begin
      int seen = 0;
      repeat (LOAD_WIN + 2) begin
        @(negedge clk);
        if (op_close) seen++;
      end
      chk("R9", "op_close while busy", seen, 0);
    end
    busy = 1'b0;
    @(negedge clk);
    do_wr(15'h2AAA, 8'h55, 1'b1, "R9");
    do_wr(15'h5555, 8'hA0, 1'b1, "R9");
    wait_close(1'b1, 1'b0, "R9");
    chk("R9", "prot_on", 32'(prot_on), 32'd0);

    // R10: functional reset keeps protection
    do_wr(15'h5555, 8'hAA, 1'b0, "R10");
    do_wr(15'h2AAA, 8'h55, 1'b0, "R10");
    do_wr(15'h5555, 8'hA0, 1'b0, "R10");
    wait_close(1'b1, 1'b0, "R10");
    busy_cyc(1'b0, 1'b1, "R10");
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "prot_on after rst_n", 32'(prot_on), 32'd1);

    // R7 under protection: breaking byte is refused data
    do_wr(15'h5555, 8'hAA, 1'b0, "R7");
    do_wr(15'h0000, 8'h12, 1'b0, "R7");
    wait_close(1'b0, 1'b1, "R7");

    // R10: initialisation reset clears protection
    init_n = 1'b0;
    repeat (2) @(negedge clk);
    init_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "prot_on after init_n", 32'(prot_on), 32'd0);
    chk("R1", "load_en after init_n", 32'(load_en), 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule